// File: doc/BRIEF.md
# Periodic Digital-Trim Seconds Divider

This block turns a stream of oscillator enables (nominally 32,768 per second) into a one-cycle seconds pulse and a one-cycle minute pulse. Crystal error is corrected without analog trim. A signed calibration word sets how many minutes, counted from the start of a repeating 64-minute cycle, have one second lengthened or shortened by a fixed number of oscillator ticks. Bits [4:0] hold a step count N from 0 to 31, and bit [5] selects the direction. With N non-zero, minutes 0 to 2N-1 of the cycle each get exactly one corrected second, and that second is the last one of the minute. A positive word shortens that second by FAST_TRIM ticks, so the clock runs faster. A negative word lengthens it by SLOW_TRIM ticks, so the clock runs slower. The step sizes are unequal on purpose.

A separate free-running divider drives a square-wave test output, 512 Hz at the defaults. It is never touched by the trim, so it can be used to measure the raw oscillator. A stop input freezes every counter in place. The calibration word is sampled on the first oscillator tick of each minute, so software can rewrite it at any time.

Control is a three-state machine that classifies the second now being counted:
- SEC_PLAIN: the second has TICKS_PER_SEC ticks.
- SEC_FAST: the second is shortened by FAST_TRIM ticks.
- SEC_SLOW: the second is lengthened by SLOW_TRIM ticks.

The transitions all happen on the final tick of a second:
- PLAIN to FAST: the next second is the last of the minute, the current minute is inside the trim window, and the sign is positive.
- PLAIN to SLOW: the same conditions, with the sign negative.
- FAST to PLAIN and SLOW to PLAIN: always taken on the final tick of the trimmed second.

Top module: `cal_trim_divider`

## Requirements
- R1: While rst_n is low, sec_tick, min_tick and ft_out are all 0, and the first minute after reset is minute 0 of the 64-minute cycle.
- R2: With cal_value[4:0] = 0, every second lasts exactly TICKS_PER_SEC enabled ticks, whatever the value of cal_value[5].
- R3: With cal_value[5] = 1 and N = cal_value[4:0] non-zero, the last second of minutes 0 to 2N-1 lasts TICKS_PER_SEC - FAST_TRIM ticks.
- R4: With cal_value[5] = 0 and N non-zero, the last second of minutes 0 to 2N-1 lasts TICKS_PER_SEC + SLOW_TRIM ticks.
- R5: Minutes 2N to 63 are never corrected, and no minute has more than one corrected second. The minute index wraps from 63 to 0, so at most 62 of every 64 minutes are corrected.
- R6: Each minute has SECS_PER_MIN seconds. sec_tick is a one-cycle pulse one clock after the final tick of a second. min_tick pulses in the same cycle as the sec_tick that ends the last second of a minute, and at no other time.
- R7: cal_value is sampled on the first enabled tick of each minute. A change made later in that minute takes effect from the next minute.
- R8: ft_out starts at 0 and inverts after every FT_HALF enabled ticks, with no dependence on cal_value.
- R9: A tick is enabled only when osc_tick = 1 and stop = 0. In any other cycle, no counter advances, no pulse is produced and ft_out holds its level. Counting resumes where it stopped, with no tick lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | One-cycle enable per oscillator period |
| stop | input | 1 | High freezes the whole divider |
| cal_value | input | 6 | [5] direction (1 = faster), [4:0] step count N |
| sec_tick | output | 1 | One-cycle pulse at the end of each second |
| min_tick | output | 1 | One-cycle pulse at the end of each minute |
| ft_out | output | 1 | Uncorrected frequency-test square wave |

## Verification
Two pairs of functions can coincide in one cycle. The end of a corrected second is also the end of its minute, so the trimmed terminal count, min_tick and the minute-index wrap all resolve in the same cycle. The bench judges this by measuring the length of every second over whole 64-minute cycles for several words and requiring min_tick exactly on the last second. Also, the sampling of the calibration word on the first tick of a minute can land in the cycle just after software writes a new word. The bench provokes this by writing the word on the clock phase right after min_tick, which must take effect at once, and then by writing mid-minute, which must be deferred by one minute.

// File: rtl/cal_trim_pkg.sv
package cal_trim_pkg;

    // Width of the minute index: the correction cycle is 64 minutes long.
    localparam int MIN_W = 6;

    // Kind of second currently being counted.
    typedef enum logic [1:0] {
        SEC_PLAIN = 2'd0,
        SEC_FAST  = 2'd1,
        SEC_SLOW  = 2'd2
    } sec_kind_e;

    // Calibration word: direction flag above a five-bit step count.
    typedef struct packed {
        logic       faster;
        logic [4:0] steps;
    } cal_word_t;

endpackage

// File: rtl/cal_test_divider.sv
module cal_test_divider #(
    parameter int FT_HALF = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_en,
    output logic ft_out
);
    localparam int HW = (FT_HALF > 1) ? $clog2(FT_HALF) : 1;
    localparam logic [HW-1:0] HALF_LAST = HW'(FT_HALF - 1);

    logic [HW-1:0] half_cnt;
    logic          ft_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_cnt <= '0;
            ft_q     <= 1'b0;
        end else if (osc_en) begin
            if (half_cnt == HALF_LAST) begin
                half_cnt <= '0;
                ft_q     <= ~ft_q;
            end else begin
                half_cnt <= half_cnt + 1'b1;
            end
        end
    end

    assign ft_out = ft_q;

    // The test output only moves on an enabled tick.
    assert_ft_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |=> $stable(ft_q));

    assert_ft_cnt_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |=> $stable(half_cnt));

endmodule

// File: rtl/cal_tick_counter.sv
module cal_tick_counter
    import cal_trim_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768,
    parameter int FAST_TRIM     = 256,
    parameter int SLOW_TRIM     = 128
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      osc_en,
    input  sec_kind_e kind,
    output logic      sec_end,
    output logic      first_tick
);
    localparam int CW = $clog2(TICKS_PER_SEC + SLOW_TRIM);
    localparam logic [CW-1:0] TERM_PLAIN = CW'(TICKS_PER_SEC - 1);
    localparam logic [CW-1:0] TERM_FAST  = CW'(TICKS_PER_SEC - 1 - FAST_TRIM);
    localparam logic [CW-1:0] TERM_SLOW  = CW'(TICKS_PER_SEC - 1 + SLOW_TRIM);

    logic [CW-1:0] tick_cnt;
    logic [CW-1:0] term;

    always_comb begin
        unique case (kind)
            SEC_FAST: term = TERM_FAST;
            SEC_SLOW: term = TERM_SLOW;
            default:  term = TERM_PLAIN;
        endcase
    end

    assign sec_end    = osc_en && (tick_cnt == term);
    assign first_tick = (tick_cnt == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_cnt <= '0;
        end else if (osc_en) begin
            if (tick_cnt == term) begin
                tick_cnt <= '0;
            end else begin
                tick_cnt <= tick_cnt + 1'b1;
            end
        end
    end

    assert_cnt_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |=> $stable(tick_cnt));

    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick_cnt <= TERM_SLOW);

    assert_fast_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == SEC_FAST) |-> (tick_cnt <= TERM_FAST));

endmodule

// File: rtl/cal_minute_seq.sv
module cal_minute_seq
    import cal_trim_pkg::*;
#(
    parameter int SECS_PER_MIN = 60
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_en,
    input  logic       sec_end,
    input  logic       first_tick,
    input  logic [5:0] cal_value,
    output sec_kind_e  kind,
    output logic       sec_tick,
    output logic       min_tick
);
    localparam int SW = (SECS_PER_MIN > 2) ? $clog2(SECS_PER_MIN) : 1;
    localparam logic [SW-1:0] SEC_LAST     = SW'(SECS_PER_MIN - 1);
    localparam logic [SW-1:0] SEC_PRE_LAST = SW'(SECS_PER_MIN - 2);

    sec_kind_e      state_q, state_d;
    logic [SW-1:0]  sec_idx;
    logic [MIN_W-1:0] min_idx;
    cal_word_t      cal_q;
    logic           going_last;
    logic           last_now;
    logic           in_window;
    logic           minute_start;

    assign going_last   = (sec_idx == SEC_PRE_LAST);
    assign last_now     = (sec_idx == SEC_LAST);
    assign in_window    = (min_idx < {cal_q.steps, 1'b0});
    assign minute_start = osc_en && first_tick && (sec_idx == '0);

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        if (sec_end) begin
            unique case (state_q)
                SEC_PLAIN: begin
                    if (going_last && in_window) begin
                        state_d = cal_q.faster ? SEC_FAST : SEC_SLOW;
                    end
                end
                SEC_FAST: state_d = SEC_PLAIN;
                SEC_SLOW: state_d = SEC_PLAIN;
                default:  state_d = SEC_PLAIN;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEC_PLAIN;
        end else begin
            state_q <= state_d;
        end
    end

    // Output and position registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_idx  <= '0;
            min_idx  <= '0;
            cal_q    <= '0;
            sec_tick <= 1'b0;
            min_tick <= 1'b0;
        end else begin
            sec_tick <= sec_end;
            min_tick <= sec_end && last_now;
            if (minute_start) begin
                cal_q <= cal_word_t'(cal_value);
            end
            if (sec_end) begin
                if (last_now) begin
                    sec_idx <= '0;
                    min_idx <= min_idx + 1'b1;
                end else begin
                    sec_idx <= sec_idx + 1'b1;
                end
            end
        end
    end

    assign kind = state_q;

    assert_trim_last_sec_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != SEC_PLAIN) |-> last_now);

    assert_trim_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != SEC_PLAIN) |-> in_window);

    assert_cal_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !minute_start |=> $stable(cal_q));

    assert_sec_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> !sec_tick);

    assert_min_needs_sec_R6: assert property (@(posedge clk) disable iff (!rst_n)
        min_tick |-> (sec_tick && (sec_idx == '0)));

endmodule

// File: rtl/cal_trim_divider.sv
module cal_trim_divider
    import cal_trim_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768,
    parameter int SECS_PER_MIN  = 60,
    parameter int FAST_TRIM     = 256,
    parameter int SLOW_TRIM     = 128,
    parameter int FT_HALF       = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_tick,
    input  logic       stop,
    input  logic [5:0] cal_value,
    output logic       sec_tick,
    output logic       min_tick,
    output logic       ft_out
);
    logic      osc_en;
    logic      sec_end;
    logic      first_tick;
    sec_kind_e kind;

    assign osc_en = osc_tick && !stop;

    cal_test_divider #(
        .FT_HALF(FT_HALF)
    ) i_test_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .osc_en (osc_en),
        .ft_out (ft_out)
    );

    cal_tick_counter #(
        .TICKS_PER_SEC (TICKS_PER_SEC),
        .FAST_TRIM     (FAST_TRIM),
        .SLOW_TRIM     (SLOW_TRIM)
    ) i_tick_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .osc_en     (osc_en),
        .kind       (kind),
        .sec_end    (sec_end),
        .first_tick (first_tick)
    );

    cal_minute_seq #(
        .SECS_PER_MIN (SECS_PER_MIN)
    ) i_min_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .osc_en     (osc_en),
        .sec_end    (sec_end),
        .first_tick (first_tick),
        .cal_value  (cal_value),
        .kind       (kind),
        .sec_tick   (sec_tick),
        .min_tick   (min_tick)
    );

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |=> !sec_tick);

endmodule

// File: tb/test_cal_trim_divider.sv
module test_cal_trim_divider;
    localparam int TPS  = 64;
    localparam int SPM  = 4;
    localparam int FAST = 8;
    localparam int SLOW = 4;
    localparam int HALF = 4;

    // Vector: {cal_value[5:0], trimmed minute count[6:0], corrected second length[7:0]}
    localparam logic [20:0] VEC [6] = '{
        {6'h00, 7'd0,  8'd64},   // R2 no trim
        {6'h20, 7'd0,  8'd64},   // R2 sign set, zero steps
        {6'h21, 7'd2,  8'd56},   // R3 one fast step
        {6'h06, 7'd12, 8'd68},   // R4 six slow steps
        {6'h3F, 7'd62, 8'd56},   // R3 R5 full fast window
        {6'h1F, 7'd62, 8'd68}    // R4 R5 full slow window
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_tick = 1'b1;
    logic       stop = 1'b0;
    logic [5:0] cal_value = 6'h00;
    logic       sec_tick, min_tick, ft_out;

    int  n_tests = 0;
    int  n_fail = 0;
    int  ticks = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    cal_trim_divider #(
        .TICKS_PER_SEC (TPS),
        .SECS_PER_MIN  (SPM),
        .FAST_TRIM     (FAST),
        .SLOW_TRIM     (SLOW),
        .FT_HALF       (HALF)
    ) i_cal_trim_divider (
        .clk       (clk),
        .rst_n     (rst_n),
        .osc_tick  (osc_tick),
        .stop      (stop),
        .cal_value (cal_value),
        .sec_tick  (sec_tick),
        .min_tick  (min_tick),
        .ft_out    (ft_out)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Counts enabled ticks up to the next sec_tick; osc_tick high, stop low.
    task automatic wait_second(output int len);
        len = 0;
        do begin
            @(negedge clk);
            len++;
            ticks++;
        end while (!sec_tick && len < 1000);
    endtask

    task automatic do_reset(input logic [5:0] cal);
        rst_n     = 1'b0;
        osc_tick  = 1'b1;
        stop      = 1'b0;
        cal_value = cal;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        ticks = 0;
    endtask

    initial begin
        int len;
        // R1: outputs quiet in reset
        rst_n = 1'b0;
        cal_value = VEC[0][20:15];
        repeat (5) @(negedge clk);
        chk(sec_tick == 1'b0, "R1 sec_tick in reset", sec_tick, 0);
        chk(min_tick == 1'b0, "R1 min_tick in reset", min_tick, 0);
        chk(ft_out == 1'b0, "R1 ft_out in reset", ft_out, 0);
        rst_n = 1'b1;
        ticks = 0;

        // Table walk: one full 64-minute cycle per vector, starting at minute 0 (R1, R5 wrap)
        foreach (VEC[v]) begin
            cal_value = VEC[v][20:15];
            for (int m = 0; m < 64; m++) begin
                for (int s = 0; s < SPM; s++) begin
                    int exp_len;
                    bit corr;
                    wait_second(len);
                    corr = (s == SPM - 1) && (m < int'(VEC[v][14:8]));
                    exp_len = corr ? int'(VEC[v][7:0]) : TPS;
                    chk(len == exp_len, "R2 R3 R4 R5 second length", len, exp_len);
                    chk(min_tick == (s == SPM - 1), "R6 min_tick placement", min_tick, (s == SPM - 1));
                    chk(ft_out == ((ticks / HALF) % 2), "R8 ft_out level", ft_out, (ticks / HALF) % 2);
                end
            end
        end

        // R7: mid-minute change is deferred to the next minute
        do_reset(6'h00);
        wait_second(len);
        cal_value = 6'h21;
        for (int s = 1; s < SPM; s++) begin
            wait_second(len);
            chk(len == TPS, "R7 old word kept in minute 0", len, TPS);
        end
        for (int s = 0; s < SPM; s++) begin
            wait_second(len);
            chk(len == ((s == SPM - 1) ? TPS - FAST : TPS), "R7 new word in minute 1", len,
                (s == SPM - 1) ? TPS - FAST : TPS);
        end

        // R9: stop and missing osc_tick freeze everything
        do_reset(6'h00);
        repeat (10) @(negedge clk);
        begin
            logic ft_hold;
            bit quiet;
            ft_hold = ft_out;
            quiet = 1'b1;
            stop = 1'b1;
            repeat (30) begin
                @(negedge clk);
                if (sec_tick || min_tick || ft_out != ft_hold) quiet = 1'b0;
            end
            stop = 1'b0;
            osc_tick = 1'b0;
            repeat (20) begin
                @(negedge clk);
                if (sec_tick || min_tick || ft_out != ft_hold) quiet = 1'b0;
            end
            osc_tick = 1'b1;
            chk(quiet, "R9 frozen while disabled", quiet, 1);
        end
        len = 0;
        do begin
            @(negedge clk);
            len++;
        end while (!sec_tick && len < 1000);
        chk(len == TPS - 10, "R9 no ticks lost across stop", len, TPS - 10);
        chk(ft_out == ((TPS / HALF) % 2), "R8 R9 ft after resume", ft_out, (TPS / HALF) % 2);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule